// File: doc/BRIEF.md
# Hashed Page Table Probe Engine

This block walks a hashed translation table held in on-chip block RAM after a translation miss. It takes a virtual page number and an address-space identifier, folds them into a starting group index, and reads one eight-entry group from the RAM on each step. All eight entries of a group are compared in the same cycle. The walk moves through consecutive groups until an entry matches, a group holds an empty slot, or the probe budget runs out.

Each run reports one of three outcomes. A hit returns the physical page number. A miss returns the group where software should place the new translation, together with that group's free-slot mask. When the budget runs out with no match and no free slot, the block raises a fault. Software does all inserts, removals and rebuilds. It removes an entry by marking it deleted, and the walk steps over such entries. The RAM sits outside the block: the engine drives a read enable and a group address, and it receives the whole group one cycle later.

Top module: `pgwalk_top`

## Requirements
- R1: The start group is a fold of the key. Bit i of the virtual page number is XORed into group-index bit (i mod GROUP_W). Bit j of the identifier is XORed into group-index bit GROUP_W-1-(j mod GROUP_W). The read of the start group is issued combinationally in the cycle where start is sampled.
- R2: Way w of a group word occupies bits [w*41 +: 41]. Inside an entry, [10:0] is the physical page, [30:11] the virtual page tag, [38:31] the identifier, [39] deleted and [40] valid. An entry matches only when valid=1, deleted=0, and both the identifier and the tag equal the key.
- R3: On a hit, hit=1 and fault=0, and the physical page comes from the lowest-numbered matching way. The insertion group is the hit group and the mask gives that group's empty ways.
- R4: An entry with valid=1 and deleted=1 is a tombstone. It never matches and it does not end the walk.
- R5: A group with any way where valid=0 and no match ends the walk as a miss: hit=0, fault=0, physical page 0, insertion group equal to that group, and mask bit w set exactly where way w has valid=0. A match in the same group takes precedence and gives a hit.
- R6: Each further probe reads group (previous+1) mod 2^GROUP_W, so the walk wraps from the last group to group 0.
- R7: After 30 probes with no match and no empty slot, fault=1, hit=0, mask=0, physical page 0, and the insertion group is the last group probed. No 31st group is read.
- R8: If start is sampled at edge E0 and the walk ends at probe n, busy is high after edges E0..E(n-1). Done is high for exactly the one cycle after edge En, and the result outputs are valid while done is high.
- R9: Start is ignored while busy or done is high. A later key on the inputs does not change the current walk or its result, and after done the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk with the key on vpnIn/asidIn |
| vpnIn | input | 20 | Virtual page number to translate |
| asidIn | input | 8 | Address-space identifier |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | Translation found |
| fault | output | 1 | Probe budget used up |
| ppnOut | output | 11 | Physical page number on a hit |
| insGroup | output | 10 | Group for insertion, or group of the hit |
| emptyMask | output | 8 | Empty ways of insGroup |
| rdEn | output | 1 | Table read enable |
| rdAddr | output | 10 | Table group address |
| rdData | input | 328 | Group word, one cycle after rdEn |

## Verification
The fault path is the hardest outcome to reach from the ports. To get it, thirty consecutive groups must all be fully occupied with non-matching entries, and the true match must sit in the thirty-first group, so that a walk that overran its budget would report a hit instead. The bench fills that run of groups directly in its RAM model. It also sets up the wrap at the last group, tombstones that mask the key ahead of the real entry, and a free slot that hides an entry lying beyond it. In every case the cycle on which done rises is compared against a behavioural walk of the same table.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

  // control -> datapath strobes
  typedef struct packed {
    logic load;     // accept a new key, issue first read
    logic advance;  // step to the next group, issue its read
    logic finish;   // capture the result of the current group
  } strobe_t;

  // datapath -> control status for the group on rdData
  typedef struct packed {
    logic anyHit;
    logic anyEmpty;
  } status_t;

endpackage

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
#(
  parameter int MAX_PROBES = 30
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  status_t stat,
  output strobe_t stb,
  output logic    busy,
  output logic    done
);
  localparam int CNT_W = $clog2(MAX_PROBES + 1);

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_DONE} state_t;

  state_t stateQ;
  logic [CNT_W-1:0] probeQ;
  logic lastProbe, endWalk;

  assign lastProbe = (probeQ == CNT_W'(MAX_PROBES - 1));
  assign endWalk   = stat.anyHit | stat.anyEmpty | lastProbe;

  always_comb begin
    stb.load    = (stateQ == S_IDLE) && start;
    stb.advance = (stateQ == S_EVAL) && !endWalk;
    stb.finish  = (stateQ == S_EVAL) && endWalk;
  end

  assign busy = (stateQ == S_EVAL);
  assign done = (stateQ == S_DONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      probeQ <= '0;
    end else begin
      case (stateQ)
        S_IDLE: if (stb.load) begin
          stateQ <= S_EVAL;
          probeQ <= '0;
        end
        S_EVAL: begin
          if (stb.finish) stateQ <= S_DONE;
          else            probeQ <= probeQ + 1'b1;
        end
        default: stateQ <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgwalk_dpath.sv
module pgwalk_dpath
  import pgwalk_pkg::*;
#(
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int PPN_W   = 11,
  parameter int WAYS    = 8,
  parameter int GROUP_W = 10,
  localparam int ENTRY_W = 2 + ASID_W + VPN_W + PPN_W,
  localparam int GBITS   = ENTRY_W * WAYS
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [VPN_W-1:0]   vpnIn,
  input  logic [ASID_W-1:0]  asidIn,
  input  logic [GBITS-1:0]   rdData,
  output status_t            stat,
  output logic               rdEn,
  output logic [GROUP_W-1:0] rdAddr,
  output logic               hit,
  output logic               fault,
  output logic [PPN_W-1:0]   ppnOut,
  output logic [GROUP_W-1:0] insGroup,
  output logic [WAYS-1:0]    emptyMask
);

  function automatic logic [GROUP_W-1:0] foldHash(logic [VPN_W-1:0] v,
                                                  logic [ASID_W-1:0] a);
    logic [GROUP_W-1:0] h;
    h = '0;
    for (int i = 0; i < VPN_W; i++)  h[i % GROUP_W] ^= v[i];
    for (int j = 0; j < ASID_W; j++) h[GROUP_W-1-(j % GROUP_W)] ^= a[j];
    return h;
  endfunction

  logic [VPN_W-1:0]   vpnQ;
  logic [ASID_W-1:0]  asidQ;
  logic [GROUP_W-1:0] grpQ;

  logic [WAYS-1:0]  wayMatch, wayEmpty;
  logic [PPN_W-1:0] wayPpn [WAYS];
  logic [PPN_W-1:0] selPpn;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [ENTRY_W-1:0] ent;
    assign ent       = rdData[w*ENTRY_W +: ENTRY_W];
    assign wayPpn[w] = ent[PPN_W-1:0];
    assign wayEmpty[w] = !ent[ENTRY_W-1];
    assign wayMatch[w] = ent[ENTRY_W-1] && !ent[ENTRY_W-2]
                      && (ent[PPN_W+VPN_W +: ASID_W] == asidQ)
                      && (ent[PPN_W +: VPN_W] == vpnQ);
  end

  // lowest-numbered matching way wins
  always_comb begin
    selPpn = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (wayMatch[w]) selPpn = wayPpn[w];
  end

  assign stat.anyHit   = |wayMatch;
  assign stat.anyEmpty = |wayEmpty;

  assign rdEn   = stb.load | stb.advance;
  assign rdAddr = stb.load ? foldHash(vpnIn, asidIn) : grpQ + 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vpnQ <= '0; asidQ <= '0; grpQ <= '0;
      hit <= 1'b0; fault <= 1'b0; ppnOut <= '0;
      insGroup <= '0; emptyMask <= '0;
    end else begin
      if (stb.load) begin
        vpnQ  <= vpnIn;
        asidQ <= asidIn;
        grpQ  <= rdAddr;
      end else if (stb.advance) begin
        grpQ  <= rdAddr;
      end
      if (stb.finish) begin
        hit       <= stat.anyHit;
        fault     <= !stat.anyHit && !stat.anyEmpty;
        ppnOut    <= stat.anyHit ? selPpn : '0;
        insGroup  <= grpQ;
        emptyMask <= wayEmpty;
      end
    end
  end

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top
  import pgwalk_pkg::*;
#(
  parameter int VPN_W      = 20,
  parameter int ASID_W     = 8,
  parameter int PPN_W      = 11,
  parameter int WAYS       = 8,
  parameter int TABLE_ENTRIES = 8192,
  parameter int MAX_PROBES = 30,
  localparam int GROUP_W = $clog2(TABLE_ENTRIES / WAYS),
  localparam int ENTRY_W = 2 + ASID_W + VPN_W + PPN_W,
  localparam int GBITS   = ENTRY_W * WAYS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [VPN_W-1:0]   vpnIn,
  input  logic [ASID_W-1:0]  asidIn,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic               fault,
  output logic [PPN_W-1:0]   ppnOut,
  output logic [GROUP_W-1:0] insGroup,
  output logic [WAYS-1:0]    emptyMask,
  output logic               rdEn,
  output logic [GROUP_W-1:0] rdAddr,
  input  logic [GBITS-1:0]   rdData
);

  strobe_t stb;
  status_t stat;

  pgwalk_ctrl #(.MAX_PROBES(MAX_PROBES)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .stb(stb), .busy(busy), .done(done)
  );

  pgwalk_dpath #(
    .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W),
    .WAYS(WAYS), .GROUP_W(GROUP_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .vpnIn(vpnIn), .asidIn(asidIn),
    .rdData(rdData), .stat(stat), .rdEn(rdEn), .rdAddr(rdAddr),
    .hit(hit), .fault(fault), .ppnOut(ppnOut),
    .insGroup(insGroup), .emptyMask(emptyMask)
  );

endmodule

// File: rtl/pgwalk_chk.sv
module pgwalk_chk #(
  parameter int WAYS       = 8,
  parameter int GROUP_W    = 10,
  parameter int MAX_PROBES = 30
) (
  input logic               clk,
  input logic               rstN,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               hit,
  input logic               fault,
  input logic [WAYS-1:0]    emptyMask,
  input logic               rdEn,
  input logic [GROUP_W-1:0] rdAddr
);
  localparam int CW = $clog2(MAX_PROBES + 2);
  logic [CW-1:0] walkCyc;

  always_ff @(posedge clk) begin
    if (!rstN)     walkCyc <= '0;
    else if (busy) walkCyc <= walkCyc + 1'b1;
    else           walkCyc <= '0;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done) |=> busy);

  // R7
  probe_budget_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (walkCyc < CW'(MAX_PROBES)));

  // R7
  fault_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && fault) |-> (emptyMask == '0 && !hit));

  // R5
  miss_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !hit && !fault) |-> (emptyMask != '0));

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && busy) |-> (rdAddr == GROUP_W'($past(rdAddr) + 1'b1)));

  // R9
  done_to_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

endmodule

bind pgwalk_top pgwalk_chk #(
  .WAYS(WAYS), .GROUP_W(GROUP_W), .MAX_PROBES(MAX_PROBES)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .hit(hit), .fault(fault), .emptyMask(emptyMask),
  .rdEn(rdEn), .rdAddr(rdAddr)
);

// File: tb/pgwalk_top_test.sv
`timescale 1ns/1ps
module pgwalk_top_test;
  localparam int VW = 20, AW = 8, PW = 11, WY = 8, GW = 10, NG = 1024;
  localparam int EW = 2 + AW + VW + PW;
  localparam int GB = EW * WY;
  localparam int LIMIT = 30;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [VW-1:0] vpnIn = '0;
  logic [AW-1:0] asidIn = '0;
  logic busy, done, hit, fault, rdEn;
  logic [PW-1:0] ppnOut;
  logic [GW-1:0] insGroup, rdAddr;
  logic [WY-1:0] emptyMask;
  logic [GB-1:0] rdData = '0;
  logic [GB-1:0] tbl [NG];

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  always @(posedge clk) if (rdEn) rdData <= tbl[rdAddr];

  pgwalk_top uut (
    .clk(clk), .rstN(rstN), .start(start), .vpnIn(vpnIn), .asidIn(asidIn),
    .busy(busy), .done(done), .hit(hit), .fault(fault), .ppnOut(ppnOut),
    .insGroup(insGroup), .emptyMask(emptyMask), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // R1 fold
  function automatic int hashOf(input int v, input int a);
    int h = 0;
    for (int i = 0; i < VW; i++) if ((v >> i) & 1) h ^= 1 << (i % GW);
    for (int j = 0; j < AW; j++) if ((a >> j) & 1) h ^= 1 << (GW - 1 - (j % GW));
    return h;
  endfunction

  function automatic logic [EW-1:0] mkEnt(input bit v, input bit d, input int a,
                                          input int vp, input int pp);
    return {v, d, AW'(a), VW'(vp), PW'(pp)};
  endfunction

  task automatic putWay(input int g, input int w, input logic [EW-1:0] e);
    tbl[g % NG][w*EW +: EW] = e;
  endtask

  task automatic fillFull(input int g, input int seed);
    for (int w = 0; w < WY; w++)
      putWay(g, w, mkEnt(1, 0, 8'hFF, 20'hF0000 + seed * 8 + w, w));
  endtask

  task automatic clearAll();
    for (int i = 0; i < NG; i++) tbl[i] = '0;
  endtask

  // behavioural walk over the bench table
  task automatic model(input int v, input int a, output int n, output bit eh,
                       output bit ef, output int ep, output int eg, output int em);
    int g = hashOf(v, a);
    n = 0; eh = 0; ef = 0; ep = 0; eg = 0; em = 0;
    for (int p = 1; p <= LIMIT; p++) begin
      int mask = 0; int found = -1;
      for (int w = 0; w < WY; w++) begin
        logic [EW-1:0] e = tbl[g][w*EW +: EW];
        if (!e[EW-1]) mask |= 1 << w;
        else if (!e[EW-2] && e[PW+VW +: AW] == AW'(a) && e[PW +: VW] == VW'(v)
                 && found < 0) found = w;
      end
      n = p; eg = g; em = mask;
      if (found >= 0) begin
        eh = 1; ep = int'(tbl[g][found*EW +: PW]); return;
      end
      if (mask != 0) return;
      if (p < LIMIT) g = (g + 1) % NG;
    end
    ef = 1;
  endtask

  task automatic lookup(input int v, input int a, input bit noise, input string req);
    int n, ep, eg, em; bit eh, ef;
    model(v, a, n, eh, ef, ep, eg, em);
    @(negedge clk);
    vpnIn = VW'(v); asidIn = AW'(a); start = 1'b1;
    for (int c = 0; c <= n + 1; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 0) begin
        start = noise;
        if (noise) begin vpnIn = ~VW'(v); asidIn = ~AW'(a); end
      end
      check(busy == (c < n), req, $sformatf("busy c=%0d", c), busy, c < n);
      check(done == (c == n), req, $sformatf("done c=%0d", c), done, c == n);
      if (c == n) begin
        check(hit == eh, req, "hit", hit, eh);
        check(fault == ef, req, "fault", fault, ef);
        check(ppnOut == PW'(ep), req, "ppn", ppnOut, ep);
        check(insGroup == GW'(eg), req, "group", insGroup, eg);
        check(emptyMask == WY'(em), req, "mask", emptyMask, em);
      end
      if (c == n + 1) start = 1'b0;
    end
    if (noise) begin
      @(posedge clk); @(negedge clk);
      check(!busy && !done, "R9", "idle after ignored start", {busy, done}, 0);
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int g;
    clearAll();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !rdEn, "R8", "reset idle", {busy, done, rdEn}, 0);
    rstN = 1'b1;

    // R5 R1: empty table, single probe miss at the hash group
    lookup(100, 0, 0, "R5");
    check(insGroup == 10'd100, "R1", "start group", insGroup, 100);

    // R2 R3: near-miss neighbours, match in way 5
    clearAll(); g = hashOf(200, 3);
    fillFull(g, 1);
    putWay(g, 0, mkEnt(1, 0, 4, 200, 7));
    putWay(g, 1, mkEnt(1, 0, 3, 201, 9));
    putWay(g, 5, mkEnt(1, 0, 3, 200, 11'h155));
    lookup(200, 3, 0, "R2");

    // R3 R5: two matches and empty ways in one group; lowest way wins
    clearAll(); g = hashOf(20'hABCDE, 8'h5A);
    fillFull(g, 2);
    putWay(g, 0, '0); putWay(g, 7, '0);
    putWay(g, 2, mkEnt(1, 0, 8'h5A, 20'hABCDE, 11'h0A1));
    putWay(g, 6, mkEnt(1, 0, 8'h5A, 20'hABCDE, 11'h3C2));
    lookup(20'hABCDE, 8'h5A, 0, "R3");
    check(ppnOut == 11'h0A1, "R3", "lowest way ppn", ppnOut, 11'h0A1);

    // R4: tombstone of the key, real entry one group on
    clearAll();
    fillFull(300, 3); putWay(300, 3, mkEnt(1, 1, 0, 300, 11'h111));
    fillFull(301, 4); putWay(301, 0, mkEnt(1, 0, 0, 300, 11'h222));
    lookup(300, 0, 0, "R4");
    check(hit && ppnOut == 11'h222, "R4", "step over tombstone", ppnOut, 11'h222);

    // R5: empty way hides a match beyond it
    clearAll();
    fillFull(400, 5); putWay(400, 4, '0);
    fillFull(401, 6); putWay(401, 1, mkEnt(1, 0, 0, 400, 11'h333));
    lookup(400, 0, 0, "R5");
    check(!hit && emptyMask == 8'h10, "R5", "miss mask", emptyMask, 8'h10);

    // R6: wrap from last group to group 0
    clearAll();
    fillFull(1023, 7);
    fillFull(0, 8); putWay(0, 7, mkEnt(1, 0, 0, 1023, 11'h444));
    lookup(1023, 0, 0, "R6");
    check(insGroup == 0, "R6", "wrapped group", insGroup, 0);

    // R7: thirty full groups, match in the thirty-first
    clearAll();
    for (int k = 0; k < LIMIT; k++) fillFull(500 + k, 10 + k);
    fillFull(530, 50); putWay(530, 2, mkEnt(1, 0, 0, 500, 11'h555));
    lookup(500, 0, 0, "R7");
    check(fault && insGroup == 10'd529, "R7", "fault group", insGroup, 529);

    // R9: start held with another key during the walk and the done cycle
    clearAll();
    fillFull(300, 3); putWay(300, 3, mkEnt(1, 1, 0, 300, 11'h111));
    fillFull(301, 4); putWay(301, 0, mkEnt(1, 0, 0, 300, 11'h222));
    lookup(300, 0, 1, "R9");

    // R8: back-to-back lookups after the ignored starts
    lookup(301, 0, 0, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule